// File: doc/BRIEF.md
# ADC Channel Conversion Sequencer

This block runs measurement rounds on a multi-channel ADC macro. The macro starts a conversion when its channel-select input moves from all-zero to one selected channel. When the macro presents a result, it raises a data-valid strobe. Between rounds the sequencer keeps the converter powered down.

A round begins with a start request and a channel enable mask. The sequencer first releases power-down and waits a fixed warm-up time. It then selects the enabled channels one at a time, in ascending index order. Each channel's result is stored in its own field of a result bus. The select always returns to all-zero before the next channel is chosen.

When every enabled channel has been handled, the sequencer raises power-down again and pulses done. A per-conversion timeout deals with a macro that never answers: it abandons that channel, sets a sticky error flag and moves on.

Top module: `adc_seq`

## Requirements
- R1: After reset, the outputs are as follows: `adc_sel_o` is zero, `adc_pd_o` is high, `done_o` and `err_o` are low, and every result field is zero.
- R2: In idle, a start with a non-zero mask drives `adc_pd_o` low on the next cycle. The first channel select rises exactly WARM cycles after `adc_pd_o` falls.
- R3: `adc_sel_o` has at most one bit set. Bit c selects channel c. Enabled channels are converted in ascending index order, and channels whose enable bit is 0 are skipped, so their result fields are left untouched.
- R4: The select is held until `adc_valid_i` is sampled high. The data is then stored in field c of `res_o` (bits c*DW to c*DW+DW-1), and `adc_sel_o` is zero on the following cycle.
- R5: Between two channels of a round, `adc_sel_o` is zero for exactly one cycle. Every change of a non-zero select passes through zero.
- R6: One cycle after the last channel's select returns to zero, `done_o` is high for exactly one cycle and `adc_pd_o` goes high in that same cycle.
- R7: If `adc_valid_i` has not arrived after TMO cycles of select, the following happens:
  - the select drops;
  - `err_o` goes high and stays high until the next accepted start;
  - that channel's field keeps its old value;
  - the round continues with the remaining channels.
- R8: `adc_valid_i` is ignored while no channel is selected: no result field changes.
- R9: A start during a round is ignored, as are changes of the mask after a start has been accepted. A start with an all-zero mask gives a `done_o` pulse on the next cycle, while `adc_pd_o` stays high and no channel is selected.
- R10: `adc_pd_o` is low whenever `adc_sel_o` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Round request, sampled in idle |
| ch_en_i | input | NCH | Channel enable mask, latched at start |
| adc_data_i | input | DW | Conversion result from the macro |
| adc_valid_i | input | 1 | Result strobe from the macro |
| adc_sel_o | output | NCH | One-hot channel select to the macro |
| adc_pd_o | output | 1 | Power-down to the macro, high means off |
| res_o | output | NCH*DW | Result fields, channel c in bits c*DW upward |
| done_o | output | 1 | One-cycle round-complete pulse |
| err_o | output | 1 | Sticky conversion-timeout flag |

## Verification
Every output of the block comes straight from a register, so each response is due at a fixed edge:
- power-down falls one edge after start;
- the select rises WARM edges after that;
- the select drops and the result field updates one edge after valid is sampled;
- done rises one edge after the last zero-select cycle.

The bench drives its inputs and samples the outputs on falling clock edges. It counts falling edges from each stimulus and checks every output at exactly the edge where the count above says it must have changed. Hold times, the warm-up length and the timeout length are measured by counting cycles, and each count is compared with the parameter.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int NCH  = 2,
  parameter int DW   = 10,
  parameter int WARM = 8,
  parameter int TMO  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NCH-1:0]    ch_en_i,
  input  logic [DW-1:0]     adc_data_i,
  input  logic              adc_valid_i,
  output logic [NCH-1:0]    adc_sel_o,
  output logic              adc_pd_o,
  output logic [NCH*DW-1:0] res_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int WW = $clog2(WARM + 1);
  localparam int TW = $clog2(TMO + 1);

  typedef enum logic [1:0] {IDLE, WARMUP, CONV, GAP} st_t;
  st_t st;

  logic [NCH-1:0]    pend, sel_q;
  logic [CW-1:0]     cur, nxt;
  logic [WW-1:0]     wcnt;
  logic [TW-1:0]     tcnt;
  logic [NCH*DW-1:0] res_q;
  logic              pd_q, done_q, err_q;

  always_comb begin
    nxt = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) nxt = CW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      pend   <= '0;
      sel_q  <= '0;
      cur    <= '0;
      wcnt   <= '0;
      tcnt   <= '0;
      res_q  <= '0;
      pd_q   <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (start_i) begin
          err_q <= 1'b0;
          if (ch_en_i == '0) begin
            done_q <= 1'b1;
          end else begin
            pend <= ch_en_i;
            pd_q <= 1'b0;
            wcnt <= '0;
            st   <= WARMUP;
          end
        end
        WARMUP: begin
          if (wcnt == WW'(WARM - 1)) begin
            sel_q <= NCH'(1) << nxt;
            cur   <= nxt;
            tcnt  <= '0;
            st    <= CONV;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        CONV: begin
          if (adc_valid_i || tcnt == TW'(TMO - 1)) begin
            if (adc_valid_i) res_q[cur*DW +: DW] <= adc_data_i;
            else             err_q <= 1'b1;
            sel_q     <= '0;
            pend[cur] <= 1'b0;
            st        <= GAP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        GAP: begin
          if (pend != '0) begin
            sel_q <= NCH'(1) << nxt;
            cur   <= nxt;
            tcnt  <= '0;
            st    <= CONV;
          end else begin
            pd_q   <= 1'b1;
            done_q <= 1'b1;
            st     <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign adc_sel_o = sel_q;
  assign adc_pd_o  = pd_q;
  assign res_o     = res_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adc_sel_o));

  // R5
  sel_via_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sel_o != '0 && !$stable(adc_sel_o)) |-> $past(adc_sel_o) == '0);

  // R10
  pd_off_when_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sel_o != '0) |-> !adc_pd_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(adc_sel_o != '0) && !$past(adc_valid_i)) |-> err_o);
endmodule

// File: tb/tb_adc_seq.sv
module tb_adc_seq;
  localparam int NCH = 2, DW = 10, WARM = 3, TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, adc_valid_i = 1'b0;
  logic [NCH-1:0] ch_en_i = '0;
  logic [DW-1:0] adc_data_i = '0;
  logic [NCH-1:0] adc_sel_o;
  logic adc_pd_o, done_o, err_o;
  logic [NCH*DW-1:0] res_o;
  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  adc_seq #(.NCH(NCH), .DW(DW), .WARM(WARM), .TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ch_en_i(ch_en_i),
    .adc_data_i(adc_data_i), .adc_valid_i(adc_valid_i), .adc_sel_o(adc_sel_o),
    .adc_pd_o(adc_pd_o), .res_o(res_o), .done_o(done_o), .err_o(err_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int field(input int c);
    return int'(res_o[c*DW +: DW]);
  endfunction

  // Runs one round; tmo_ch selects a channel that never answers (-1: none).
  task automatic run_round(input logic [1:0] mask, input int lat,
                           input logic [9:0] d0, input logic [9:0] d1, input int tmo_ch);
    int wc;
    bit first;
    @(negedge clk); start_i = 1'b1; ch_en_i = mask;
    @(negedge clk); start_i = 1'b0; ch_en_i = ~mask;
    check(adc_pd_o == 1'b0, "R2 pd released", adc_pd_o, 0);
    check(err_o == 1'b0, "R7 err cleared by start", err_o, 0);
    wc = 0;
    while (adc_sel_o == '0 && wc < 50) begin @(negedge clk); wc++; end
    check(wc == WARM, "R2 warm-up length", wc, WARM);
    first = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      if (mask[c]) begin
        if (!first) begin
          @(negedge clk);
        end
        first = 1'b0;
        check(adc_sel_o == 2'(1 << c), "R3 channel order", adc_sel_o, 1 << c);
        check(adc_pd_o == 1'b0, "R10 pd low while selected", adc_pd_o, 0);
        if (c == tmo_ch) begin
          int h = 1;
          int old = field(c);
          while (1) begin
            @(negedge clk);
            if (adc_sel_o != '0) h++; else break;
          end
          check(h == TMO, "R7 timeout length", h, TMO);
          check(err_o == 1'b1, "R7 err set", err_o, 1);
          check(field(c) == old, "R7 field kept", field(c), old);
        end else begin
          for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            check(adc_sel_o == 2'(1 << c), "R4 select held", adc_sel_o, 1 << c);
          end
          adc_valid_i = 1'b1; adc_data_i = (c == 0) ? d0 : d1;
          @(negedge clk); adc_valid_i = 1'b0; adc_data_i = '0;
          check(adc_sel_o == '0, "R4 select drops", adc_sel_o, 0);
          check(field(c) == ((c == 0) ? d0 : d1), "R4 result stored", field(c), (c == 0) ? d0 : d1);
        end
        check(adc_sel_o == '0 && done_o == 1'b0, "R5 zero gap", adc_sel_o, 0);
      end
    end
    @(negedge clk);
    check(done_o == 1'b1, "R6 done pulse", done_o, 1);
    check(adc_pd_o == 1'b1, "R6 pd reasserted", adc_pd_o, 1);
    @(negedge clk);
    check(done_o == 1'b0, "R6 done one cycle", done_o, 0);
    ch_en_i = '0;
  endtask

  task automatic t_reset;
    check(adc_sel_o == '0, "R1 sel", adc_sel_o, 0);
    check(adc_pd_o == 1'b1, "R1 pd", adc_pd_o, 1);
    check(done_o == 1'b0 && err_o == 1'b0, "R1 flags", {done_o, err_o}, 0);
    check(res_o == '0, "R1 results", int'(res_o), 0);
  endtask

  task automatic t_both;
    run_round(2'b11, 2, 10'h2A5, 10'h15A, -1);
    run_round(2'b11, 0, 10'h3FF, 10'h001, -1);
  endtask

  task automatic t_skip;
    int old0 = field(0);
    run_round(2'b10, 4, 10'h000, 10'h0C3, -1);
    check(field(0) == old0, "R3 disabled channel untouched", field(0), old0);
  endtask

  task automatic t_timeout;
    run_round(2'b11, 1, 10'h111, 10'h222, 1);
    check(err_o == 1'b1, "R7 err sticky", err_o, 1);
    run_round(2'b01, 1, 10'h0F0, 10'h000, -1);
  endtask

  task automatic t_idle_valid;
    logic [NCH*DW-1:0] old = res_o;
    @(negedge clk); adc_valid_i = 1'b1; adc_data_i = 10'h155;
    @(negedge clk); adc_valid_i = 1'b0; adc_data_i = '0;
    @(negedge clk);
    check(res_o == old, "R8 idle valid ignored", int'(res_o), int'(old));
    check(adc_sel_o == '0, "R8 no select", adc_sel_o, 0);
  endtask

  task automatic t_busy_start;
    int wc = 0;
    @(negedge clk); start_i = 1'b1; ch_en_i = 2'b01;
    @(negedge clk); ch_en_i = 2'b10;
    @(negedge clk); start_i = 1'b0;
    while (adc_sel_o == '0 && wc < 50) begin @(negedge clk); wc++; end
    check(adc_sel_o == 2'b01, "R9 busy start ignored", adc_sel_o, 1);
    adc_valid_i = 1'b1; adc_data_i = 10'h077;
    @(negedge clk); adc_valid_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b1 && adc_sel_o == '0, "R9 no extra channel", done_o, 1);
    ch_en_i = '0;
  endtask

  task automatic t_empty;
    @(negedge clk); start_i = 1'b1; ch_en_i = 2'b00;
    @(negedge clk); start_i = 1'b0;
    check(done_o == 1'b1, "R9 empty done", done_o, 1);
    check(adc_pd_o == 1'b1 && adc_sel_o == '0, "R9 empty stays off", adc_pd_o, 1);
    @(negedge clk);
    check(done_o == 1'b0, "R9 empty done pulse", done_o, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_both();
    t_skip();
    t_timeout();
    t_idle_valid();
    t_busy_start();
    t_empty();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule